// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is the arithmetic logic unit of a small processor datapath. It takes two operand words and a two-bit function code, and it returns a result word together with three condition flags: signed overflow, zero and carry/borrow. It has no clock and holds no state. Its outputs follow its inputs through combinational logic, so a later pipeline stage can capture the result and the flags on its own clock edge.

The function code picks one of four operations: sum, difference, bitwise AND or bitwise XOR. The difference is the second operand word minus the first, so the operand on `a_i` is the subtrahend. The flags are produced for every operation. Their meaning depends on the operation: the two logical functions always clear overflow and carry. Capturing the flags into registers, choosing the operands and decoding instructions are all handled elsewhere.

Top module: `alu_core`

## Requirements
- R1: With fn_i = 0 (add), result_o equals a_i + b_i modulo 2^WIDTH.
- R2: With fn_i = 1 (subtract), result_o equals b_i - a_i modulo 2^WIDTH.
- R3: With fn_i = 2, result_o is a_i AND b_i. With fn_i = 3, result_o is a_i XOR b_i.
- R4: For every function, zf_o is 1 exactly when all bits of result_o are 0.
- R5: With fn_i = 0, of_o is 1 exactly when a_i and b_i have the same sign bit (bit WIDTH-1) and result_o has the other sign bit, which is two's-complement overflow of the sum.
- R6: With fn_i = 1, of_o is 1 exactly when the signed difference b_i - a_i lies outside the two's-complement range of WIDTH bits.
- R7: With fn_i = 0, cf_o is the carry out of bit WIDTH-1 of the unsigned sum.
- R8: With fn_i = 1, cf_o is the borrow: 1 exactly when a_i is greater than b_i as unsigned numbers.
- R9: With fn_i = 2 or 3, of_o and cf_o are both 0.
- R10: The outputs depend only on the current inputs. A change of the inputs between clock edges shows at the outputs with no clock edge in between.
- R11: The requirements above hold for any WIDTH, including WIDTH = 4 as well as the default of 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand word (the subtrahend for subtract) |
| b_i | input | WIDTH | Second operand word (the minuend for subtract) |
| fn_i | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| result_o | output | WIDTH | Result word |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero-result flag |
| cf_o | output | 1 | Carry (add) or borrow (subtract) flag |

## Verification
Assertions inside the top module run whenever an input changes. They check the arithmetic identities for the full sum with carry, the difference added back to the subtrahend, the borrow compared with an unsigned magnitude test, the zero flag against the result word, the sign rule for overflow on addition, and the cleared flags under the logical functions. The signed overflow of subtraction, the exact bitwise results and behaviour at a width other than the default are shown only by the bench scenarios. These are an exhaustive sweep of a 4-bit instance, random 32-bit operands under every function code, and named corner cases: the largest positive value plus one, the most negative value minus one, equal operands under subtraction, and a sum that wraps to zero.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] op_x, op_y;
  logic             c_out;

  // subtract computes b + ~a + 1
  assign op_x = sub_i ? b_i : a_i;
  assign op_y = sub_i ? ~a_i : b_i;
  assign {c_out, sum_o} = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, sub_i};

  // carry for add, borrow (inverted carry) for subtract
  assign carry_o = c_out ^ sub_i;
  assign ovf_o   = (op_x[MSB] == op_y[MSB]) && (sum_o[MSB] != op_x[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] xor_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign xor_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] result_o,
  output logic             of_o,
  output logic             zf_o,
  output logic             cf_o
);
  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn;
  logic [WIDTH-1:0] arith_sum, and_w, xor_w;
  logic             arith_c, arith_v, is_arith;

  assign fn       = alu_fn_e'(fn_i);
  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (fn == FN_SUB),
    .sum_o   (arith_sum),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .xor_o (xor_w)
  );

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB: result_o = arith_sum;
      FN_AND:         result_o = and_w;
      default:        result_o = xor_w;
    endcase
  end

  assign of_o = is_arith & arith_v;
  assign cf_o = is_arith & arith_c;
  assign zf_o = ~|result_o;

  always_comb begin
    if (fn == FN_ADD) begin
      assert_add_sum_R1: assert ({cf_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("R1/R7 sum or carry mismatch");
      if (of_o) begin
        assert_add_sign_R5: assert ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB]))
          else $error("R5 overflow without sign rule");
      end
    end
    if (fn == FN_SUB) begin
      assert_sub_back_R2: assert (WIDTH'(result_o + a_i) == b_i)
        else $error("R2 difference mismatch");
      assert_sub_borrow_R8: assert (cf_o == (a_i > b_i))
        else $error("R8 borrow mismatch");
    end
    if (!is_arith) begin
      assert_logic_flags_R9: assert (!of_o && !cf_o)
        else $error("R9 flag set on logical op");
    end
    if (zf_o) begin
      assert_zero_flag_R4: assert (result_o == '0)
        else $error("R4 zero flag with nonzero result");
    end
  end
endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a = '0, b = '0;
  logic [1:0]    fn = 2'd0;
  logic [W-1:0]  res;
  logic          of, zf, cf;
  logic [WS-1:0] sa = '0, sb = '0;
  logic [1:0]    sfn = 2'd0;
  logic [WS-1:0] sres;
  logic          sof, szf, scf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu_core #(.WIDTH(W)) u_alu_core (
    .a_i(a), .b_i(b), .fn_i(fn), .result_o(res), .of_o(of), .zf_o(zf), .cf_o(cf)
  );

  alu_core #(.WIDTH(WS)) u_alu_core_w4 (
    .a_i(sa), .b_i(sb), .fn_i(sfn), .result_o(sres), .of_o(sof), .zf_o(szf), .cf_o(scf)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // arithmetic reference at width w
  task automatic model(input int w, input longint ua, input longint ub, input int f,
                       output longint r, output bit v, output bit z, output bit c);
    longint mask, half, sa_v, sb_v, full, ss;
    mask = (64'sd1 <<< w) - 1;
    half = 64'sd1 <<< (w - 1);
    sa_v = (ua >= half) ? ua - (64'sd1 <<< w) : ua;
    sb_v = (ub >= half) ? ub - (64'sd1 <<< w) : ub;
    v = 1'b0; c = 1'b0;
    case (f)
      0: begin
        full = ua + ub; r = full & mask; c = full > mask;
        ss = sa_v + sb_v; v = (ss > half - 1) || (ss < -half);
      end
      1: begin
        full = ub - ua; r = full & mask; c = ua > ub;
        ss = sb_v - sa_v; v = (ss > half - 1) || (ss < -half);
      end
      2: r = ua & ub;
      default: r = ua ^ ub;
    endcase
    z = (r == 0);
  endtask

  function automatic string res_tag(input int f);
    return (f == 0) ? "R1 result" : (f == 1) ? "R2 result" : "R3 result";
  endfunction
  function automatic string of_tag(input int f);
    return (f == 0) ? "R5 of" : (f == 1) ? "R6 of" : "R9 of";
  endfunction
  function automatic string cf_tag(input int f);
    return (f == 0) ? "R7 cf" : (f == 1) ? "R8 cf" : "R9 cf";
  endfunction

  task automatic run32(input logic [W-1:0] av, input logic [W-1:0] bv, input int f);
    longint r; bit v, z, c;
    @(negedge clk);
    a = av; b = bv; fn = 2'(f);
    #1;
    model(W, longint'(av), longint'(bv), f, r, v, z, c);
    check(res_tag(f), longint'(res), r);
    check(of_tag(f), longint'(of), longint'(v));
    check("R4 zf", longint'(zf), longint'(z));
    check(cf_tag(f), longint'(cf), longint'(c));
  endtask

  task automatic run4(input int av, input int bv, input int f);
    longint r; bit v, z, c;
    @(negedge clk);
    sa = WS'(av); sb = WS'(bv); sfn = 2'(f);
    #1;
    model(WS, longint'(av), longint'(bv), f, r, v, z, c);
    check({"R11 ", res_tag(f)}, longint'(sres), r);
    check({"R11 ", of_tag(f)}, longint'(sof), longint'(v));
    check("R11 R4 zf", longint'(szf), longint'(z));
    check({"R11 ", cf_tag(f)}, longint'(scf), longint'(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // idle inputs: add of zeros
    check("R1 idle result", longint'(res), 0);
    check("R4 idle zf", longint'(zf), 1);

    // corner cases with literal expectations
    run32(32'h0000_0001, 32'h7FFF_FFFF, 0);
    check("R5 max+1 of", longint'(of), 1);
    check("R1 max+1 result", longint'(res), 64'h8000_0000);
    run32(32'h0000_0001, 32'h8000_0000, 1);
    check("R6 min-1 of", longint'(of), 1);
    check("R2 min-1 result", longint'(res), 64'h7FFF_FFFF);
    run32(32'h1234_5678, 32'h1234_5678, 1);
    check("R4 equal sub zf", longint'(zf), 1);
    check("R8 equal sub no borrow", longint'(cf), 0);
    run32(32'h0000_0001, 32'hFFFF_FFFF, 0);
    check("R7 wrap carry", longint'(cf), 1);
    check("R4 wrap zf", longint'(zf), 1);
    run32(32'h0000_0002, 32'h0000_0001, 1);
    check("R8 borrow", longint'(cf), 1);
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);
    check("R9 xor self flags", longint'({of, cf}), 0);

    // R10: input change mid-cycle, outputs read with no edge between
    @(negedge clk);
    a = 32'h0000_00F0; b = 32'h0000_000F; fn = 2'd2;
    #0.5;
    check("R10 and settles", longint'(res), 0);
    a = 32'h0000_00FF; fn = 2'd3;
    #0.5;
    check("R10 xor settles", longint'(res), 64'hF0);

    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 1500; i++) begin
        run32($urandom(), $urandom(), f);
      end
    end

    for (int f = 0; f < 4; f++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run4(x, y, f);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule